// File: doc/BRIEF.md
# Line-Hinted Write-Back Data Cache Controller

This block is a direct-mapped, write-back data cache controller with 64-byte lines. A requester issues ordinary loads and stores with a 64-bit word, byte enables and an address. It can also issue five line-granular hint operations that change the state of a whole aligned line directly: a plain prefetch, a prefetch that installs the line already dirty, a prefetch that marks the line for early eviction, a write hint that claims a line without reading memory, and an explicit evict.

The controller serves one request at a time. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` stays low while the lookup, any writeback and any fill are in progress. Load data comes back on `rsp_valid`/`rsp_data`. The memory side moves whole lines. A read or write request is held until the memory returns a single-cycle `mem_ack`.

Each line holds a tag, a valid bit, a dirty bit and an evict-next mark. A dirty line is always written back before it is replaced or evicted. A clean line is simply dropped.

Top module: `cache_hint_ctrl`

## Requirements
- R1: Load (op 0) returns the 64-bit word selected by address bits [5:3] of its line, with `rsp_valid` high for exactly one cycle. A load that hits causes no memory traffic.
- R2: Store (op 1) that hits writes byte i of the selected word only where `req_be[i]` is 1. It marks the line dirty and causes no memory traffic.
- R3: A load or store that misses first writes back the resident line if that line is dirty. It then performs exactly one line read and completes as a hit on the filled line.
- R4: Prefetch (op 2) that misses reads the line once, returns no response and installs the line clean, so a later displacement causes no writeback. A prefetch that hits causes no traffic.
- R5: Prefetch-for-modify (op 3) installs the line dirty. On a clean hit it only sets the dirty bit, with no traffic. In both cases a later displacement writes the line back.
- R6: Write hint (op 5) never issues a memory read. It installs the line valid and dirty with all bytes zero. A dirty resident line with another tag is written back first.
- R7: Prefetch-evict-next (op 4) installs the line clean and marked. The next fill at that index displaces it without a writeback. A mark is only set on a clean line, and it is dropped when the line turns dirty.
- R8: Evict (op 6) of a dirty hit writes the line back once and invalidates it. Evict of a clean hit invalidates with no traffic. Evict of a miss does nothing. Evict never reads memory.
- R9: One request is in flight at a time. `req_ready` is low whenever a memory request is raised. A memory request and its line address are held until `mem_ack`. Read and write requests are never raised together.
- R10: Op 7 is reserved and has no effect on any line and no memory traffic.
- R11: After reset `req_ready` is 1, `rsp_valid`, `mem_rd_req` and `mem_wr_req` are 0, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken this cycle if valid |
| req_op | input | 3 | Operation code (0 load … 7 reserved) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | WORD_W | Store data |
| req_be | input | WORD_W/8 | Store byte enables |
| rsp_valid | output | 1 | Load data valid (one cycle) |
| rsp_data | output | WORD_W | Load data |
| mem_rd_req | output | 1 | Line read request, held until ack |
| mem_wr_req | output | 1 | Line write request, held until ack |
| mem_line_addr | output | ADDR_W-6 | Line address of the memory request |
| mem_wdata | output | LINE_BYTES*8 | Line written back |
| mem_rdata | input | LINE_BYTES*8 | Line returned, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the current memory request |

## Verification
The checks assume that the memory pulses `mem_ack` for one cycle only while a read or write request is raised. They also assume that `mem_rdata` is valid in that same cycle. The bench memory meets this by counting a fixed latency from the request, raising the acknowledge on a falling edge and dropping it one cycle later. Request fields are only trusted in the cycle the request is taken. The bench drives them on falling edges and withdraws `req_valid` right after acceptance.

// File: rtl/cc_pkg.sv
package cc_pkg;

   typedef enum logic [2:0] {
      OP_LOAD    = 3'd0,
      OP_STORE   = 3'd1,
      OP_PF      = 3'd2,
      OP_PF_MOD  = 3'd3,
      OP_PF_EVN  = 3'd4,
      OP_WH      = 3'd5,
      OP_EVICT   = 3'd6,
      OP_NOP     = 3'd7
   } cc_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOOK,
      ST_WB,
      ST_FILL
   } cc_st_e;

endpackage

// File: rtl/cc_tag_array.sv
module cc_tag_array #(
   parameter int LINES = 8,
   parameter int TAG_W = 7,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             inst_en,
   input  logic [TAG_W-1:0] inst_tag,
   input  logic             dirty_set,
   input  logic             evn_set,
   input  logic             inval_en,
   output logic             rd_valid,
   output logic             rd_dirty,
   output logic             rd_evn,
   output logic [TAG_W-1:0] rd_tag
);

   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [LINES-1:0] evn_q;
   logic [TAG_W-1:0] tag_q [LINES];

   assign rd_valid = valid_q[idx];
   assign rd_dirty = dirty_q[idx];
   assign rd_evn   = evn_q[idx];
   assign rd_tag   = tag_q[idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
         evn_q   <= '0;
         for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
      end else if (inval_en) begin
         valid_q[idx] <= 1'b0;
         dirty_q[idx] <= 1'b0;
         evn_q[idx]   <= 1'b0;
      end else if (inst_en) begin
         valid_q[idx] <= 1'b1;
         dirty_q[idx] <= 1'b0;
         evn_q[idx]   <= 1'b0;
         tag_q[idx]   <= inst_tag;
      end else if (dirty_set) begin
         dirty_q[idx] <= 1'b1;
         evn_q[idx]   <= 1'b0;
      end else if (evn_set && !dirty_q[idx]) begin
         evn_q[idx]   <= 1'b1;
      end
   end

endmodule

// File: rtl/cc_line_store.sv
module cc_line_store #(
   parameter int LINES      = 8,
   parameter int LINE_BYTES = 64,
   parameter int WORD_W     = 64,
   localparam int LINE_W = LINE_BYTES * 8,
   localparam int IDX_W  = $clog2(LINES),
   localparam int BE_W   = WORD_W / 8,
   localparam int WSEL_W = $clog2(LINE_W / WORD_W)
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx,
   input  logic              line_we,
   input  logic [LINE_W-1:0] line_wdata,
   input  logic              word_we,
   input  logic [WSEL_W-1:0] wsel,
   input  logic [BE_W-1:0]   be,
   input  logic [WORD_W-1:0] wdata,
   output logic [LINE_W-1:0] rd_line,
   output logic [WORD_W-1:0] rd_word
);

   logic [LINE_W-1:0] mem_q [LINES];
   logic [LINE_W-1:0] merged;

   assign rd_line = mem_q[idx];
   assign rd_word = rd_line[wsel*WORD_W +: WORD_W];

   for (genvar g = 0; g < LINE_BYTES; g++) begin : g_byte
      localparam int WI = g / BE_W;
      localparam int LI = g % BE_W;
      assign merged[g*8 +: 8] = (wsel == WSEL_W'(WI) && be[LI]) ?
                                wdata[LI*8 +: 8] : rd_line[g*8 +: 8];
   end

   always_ff @(posedge clk) begin
      if (line_we)      mem_q[idx] <= line_wdata;
      else if (word_we) mem_q[idx] <= merged;
   end

endmodule

// File: rtl/cc_ctrl.sv
module cc_ctrl
   import cc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [2:0] req_op,
   input  logic       hit,
   input  logic       vic_wb,
   input  logic       mem_ack,
   output logic       req_ready,
   output cc_op_e     op_q,
   output logic       in_look,
   output logic       in_wb,
   output logic       in_fill,
   output logic       install_fill,
   output logic       install_zero,
   output logic       inval
);

   cc_st_e st_q, st_d;

   always_comb begin
      st_d         = st_q;
      req_ready    = 1'b0;
      install_fill = 1'b0;
      install_zero = 1'b0;
      inval        = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            req_ready = 1'b1;
            if (req_valid) st_d = ST_LOOK;
         end
         ST_LOOK: begin
            if (op_q == OP_EVICT) begin
               if (hit && vic_wb) begin
                  st_d = ST_WB;
               end else begin
                  inval = hit;
                  st_d  = ST_IDLE;
               end
            end else if (op_q == OP_NOP || hit) begin
               st_d = ST_IDLE;
            end else if (vic_wb) begin
               st_d = ST_WB;
            end else if (op_q == OP_WH) begin
               install_zero = 1'b1;
            end else begin
               st_d = ST_FILL;
            end
         end
         ST_WB: begin
            if (mem_ack) begin
               if (op_q == OP_EVICT) begin
                  inval = 1'b1;
                  st_d  = ST_IDLE;
               end else if (op_q == OP_WH) begin
                  install_zero = 1'b1;
                  st_d         = ST_LOOK;
               end else begin
                  st_d = ST_FILL;
               end
            end
         end
         ST_FILL: begin
            if (mem_ack) begin
               install_fill = 1'b1;
               st_d         = ST_LOOK;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         op_q <= OP_NOP;
      end else begin
         st_q <= st_d;
         if (req_valid && req_ready) op_q <= cc_op_e'(req_op);
      end
   end

   assign in_look = (st_q == ST_LOOK);
   assign in_wb   = (st_q == ST_WB);
   assign in_fill = (st_q == ST_FILL);

endmodule

// File: rtl/cache_hint_ctrl.sv
module cache_hint_ctrl
   import cc_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int WORD_W     = 64,
   parameter int LINE_BYTES = 64,
   parameter int LINES      = 8,
   parameter int ZERO_ON_WH = 1,
   localparam int LINE_W  = LINE_BYTES * 8,
   localparam int BE_W    = WORD_W / 8,
   localparam int OFF_W   = $clog2(LINE_BYTES),
   localparam int LADDR_W = ADDR_W - OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [2:0]         req_op,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [WORD_W-1:0]  req_wdata,
   input  logic [BE_W-1:0]    req_be,
   output logic               rsp_valid,
   output logic [WORD_W-1:0]  rsp_data,
   output logic               mem_rd_req,
   output logic               mem_wr_req,
   output logic [LADDR_W-1:0] mem_line_addr,
   output logic [LINE_W-1:0]  mem_wdata,
   input  logic [LINE_W-1:0]  mem_rdata,
   input  logic               mem_ack
);

   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
   localparam int WORDS  = LINE_W / WORD_W;
   localparam int WSEL_W = $clog2(WORDS);

   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < 16) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 16");
   end
   if ((WORD_W & (WORD_W - 1)) != 0 || WORD_W < 8 || WORDS < 2) begin : g_bad_word
      $error("WORD_W must be a power of two, at least 8, and below the line width");
   end
   if ((LINES & (LINES - 1)) != 0 || LINES < 2) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for the chosen geometry");
   end

   // request capture
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] wdata_q;
   logic [BE_W-1:0]   be_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         be_q    <= '0;
      end else if (req_valid && req_ready) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         be_q    <= req_be;
      end
   end

   logic [IDX_W-1:0]  idx;
   logic [TAG_W-1:0]  tag_in;
   logic [WSEL_W-1:0] wsel;

   assign idx    = addr_q[OFF_W +: IDX_W];
   assign tag_in = addr_q[ADDR_W-1 -: TAG_W];
   assign wsel   = addr_q[OFF_W-1 -: WSEL_W];

   // line state
   logic             t_valid, t_dirty, t_evn;
   logic [TAG_W-1:0] t_tag;
   logic             hit, vic_wb;
   cc_op_e           op_q;
   logic             in_look, in_wb, in_fill;
   logic             install_fill, install_zero, inval;
   logic             hit_act, dirty_set, evn_set, word_we, line_we;
   logic [LINE_W-1:0] rd_line, line_wdata;
   logic [WORD_W-1:0] rd_word;

   assign hit    = t_valid && (t_tag == tag_in);
   assign vic_wb = t_valid && t_dirty && !t_evn;

   assign hit_act   = in_look && hit;
   assign dirty_set = hit_act && (op_q == OP_STORE || op_q == OP_PF_MOD || op_q == OP_WH);
   assign evn_set   = hit_act && (op_q == OP_PF_EVN);
   assign word_we   = hit_act && (op_q == OP_STORE);

   cc_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) i_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx       (idx),
      .inst_en   (install_fill || install_zero),
      .inst_tag  (tag_in),
      .dirty_set (dirty_set),
      .evn_set   (evn_set),
      .inval_en  (inval),
      .rd_valid  (t_valid),
      .rd_dirty  (t_dirty),
      .rd_evn    (t_evn),
      .rd_tag    (t_tag)
   );

   cc_ctrl i_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_op       (req_op),
      .hit          (hit),
      .vic_wb       (vic_wb),
      .mem_ack      (mem_ack),
      .req_ready    (req_ready),
      .op_q         (op_q),
      .in_look      (in_look),
      .in_wb        (in_wb),
      .in_fill      (in_fill),
      .install_fill (install_fill),
      .install_zero (install_zero),
      .inval        (inval)
   );

   // write-hint contents: cleared or left as they were
   if (ZERO_ON_WH != 0) begin : g_wh_zero
      assign line_we = install_fill || install_zero;
   end else begin : g_wh_keep
      assign line_we = install_fill;
   end
   assign line_wdata = install_fill ? mem_rdata : '0;

   cc_line_store #(.LINES(LINES), .LINE_BYTES(LINE_BYTES), .WORD_W(WORD_W)) i_data (
      .clk        (clk),
      .idx        (idx),
      .line_we    (line_we),
      .line_wdata (line_wdata),
      .word_we    (word_we),
      .wsel       (wsel),
      .be         (be_q),
      .wdata      (wdata_q),
      .rd_line    (rd_line),
      .rd_word    (rd_word)
   );

   // memory port
   assign mem_rd_req    = in_fill;
   assign mem_wr_req    = in_wb;
   assign mem_line_addr = in_wb ? {t_tag, idx} : addr_q[ADDR_W-1:OFF_W];
   assign mem_wdata     = rd_line;

   // load response
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= hit_act && (op_q == OP_LOAD);
         if (hit_act && op_q == OP_LOAD) rsp_data <= rd_word;
      end
   end

endmodule

// File: rtl/cc_chk.sv
module cc_chk
   import cc_pkg::*;
#(
   parameter int LADDR_W = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic [2:0]         req_op,
   input logic               rsp_valid,
   input logic               mem_rd_req,
   input logic               mem_wr_req,
   input logic [LADDR_W-1:0] mem_line_addr,
   input logic               mem_ack,
   input logic               t_dirty,
   input logic               t_evn
);

   logic [2:0] op_seen;

   always_ff @(posedge clk) begin
      if (!rst_n)                      op_seen <= OP_NOP;
      else if (req_valid && req_ready) op_seen <= req_op;
   end

   // R9
   mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_req && mem_wr_req));

   // R9
   busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req || mem_wr_req) |-> !req_ready);

   // R9
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_ack) |=> (mem_rd_req && $stable(mem_line_addr)));

   // R9
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_req && !mem_ack) |=> (mem_wr_req && $stable(mem_line_addr)));

   // R1
   rsp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (op_seen == OP_LOAD));

   // R1
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R6
   wh_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_seen == OP_WH) |-> !mem_rd_req);

   // R8
   evict_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_seen == OP_EVICT) |-> !mem_rd_req);

   // R7
   evn_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      t_evn |-> !t_dirty);

endmodule

bind cache_hint_ctrl cc_chk #(.LADDR_W(LADDR_W)) i_cc_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_op        (req_op),
   .rsp_valid     (rsp_valid),
   .mem_rd_req    (mem_rd_req),
   .mem_wr_req    (mem_wr_req),
   .mem_line_addr (mem_line_addr),
   .mem_ack       (mem_ack),
   .t_dirty       (t_dirty),
   .t_evn         (t_evn)
);

// File: tb/test_cache_hint_ctrl.sv
`timescale 1ns/1ps
module test_cache_hint_ctrl;
   import cc_pkg::*;

   localparam int LW = 512;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [2:0]    req_op = 3'd7;
   logic [15:0]   req_addr = '0;
   logic [63:0]   req_wdata = '0;
   logic [7:0]    req_be = '0;
   logic          rsp_valid;
   logic [63:0]   rsp_data;
   logic          mem_rd_req, mem_wr_req;
   logic [9:0]    mem_line_addr;
   logic [LW-1:0] mem_wdata;
   logic [LW-1:0] mem_rdata;
   logic          mem_ack;

   always #2.5 clk = ~clk;

   cache_hint_ctrl i_cache_hint_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
      .mem_line_addr(mem_line_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   function automatic logic [LW-1:0] init_line(int n);
      logic [LW-1:0] v;
      for (int w = 0; w < 8; w++)
         v[w*64 +: 64] = {16'hC0DE, 8'(n), 8'(w), 32'h1234_0000 + 32'(n * 8 + w)};
      return v;
   endfunction

   // behavioural memory
   logic [LW-1:0] mem_arr [64];
   int            lat;
   int            rd_cnt, wr_cnt;

   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
         lat       <= 0;
         rd_cnt    <= 0;
         wr_cnt    <= 0;
         for (int i = 0; i < 64; i++) mem_arr[i] <= init_line(i);
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (mem_rd_req || mem_wr_req) begin
         if (lat == 2) begin
            lat     <= 0;
            mem_ack <= 1'b1;
            if (mem_rd_req) begin
               mem_rdata <= mem_arr[mem_line_addr[5:0]];
               rd_cnt    <= rd_cnt + 1;
            end else begin
               mem_arr[mem_line_addr[5:0]] <= mem_wdata;
               wr_cnt <= wr_cnt + 1;
            end
         end else begin
            lat <= lat + 1;
         end
      end
   end

   // scoreboard monitor
   logic [63:0] exp_q [$];
   int          mon_total = 0, mon_bad = 0;

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         mon_total++;
         if (exp_q.size() == 0) begin
            mon_bad++;
            $display("FAIL R1 unexpected response act=%h exp=none", rsp_data);
         end else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            if (rsp_data !== e) begin
               mon_bad++;
               $display("FAIL R1 load data act=%h exp=%h", rsp_data, e);
            end
         end
      end
   end

   // reference model
   logic [LW-1:0] exp_mem [64];
   logic [LW-1:0] m_data  [8];
   logic [6:0]    m_tag   [8];
   logic [7:0]    m_valid = '0, m_dirty = '0;
   int            total = 0, bad = 0;

   task automatic chk(bit ok, string rq, string what, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0d exp=%0d", rq, what, act, exp);
      end
   endtask

   task automatic do_op(cc_op_e op, logic [15:0] a, logic [63:0] wd, logic [7:0] be, string rq);
      int idx, ws, ln, vl, er, ew, r0, w0;
      logic [6:0] tg;
      bit h;
      idx = int'(a[8:6]); tg = a[15:9]; ln = int'(a[11:6]); ws = int'(a[5:3]);
      h = m_valid[idx] && m_tag[idx] == tg;
      vl = int'({m_tag[idx][2:0], a[8:6]});
      er = 0; ew = 0;
      if (op == OP_EVICT) begin
         if (h) begin
            if (m_dirty[idx]) begin ew = 1; exp_mem[vl] = m_data[idx]; end
            m_valid[idx] = 1'b0; m_dirty[idx] = 1'b0;
         end
      end else if (op != OP_NOP) begin
         if (!h) begin
            if (m_valid[idx] && m_dirty[idx]) begin ew = 1; exp_mem[vl] = m_data[idx]; end
            if (op == OP_WH) m_data[idx] = '0;
            else begin er = 1; m_data[idx] = exp_mem[ln]; end
            m_valid[idx] = 1'b1; m_tag[idx] = tg; m_dirty[idx] = 1'b0;
         end
         case (op)
            OP_LOAD:  exp_q.push_back(m_data[idx][ws*64 +: 64]);
            OP_STORE: begin
               for (int b = 0; b < 8; b++)
                  if (be[b]) m_data[idx][ws*64 + b*8 +: 8] = wd[b*8 +: 8];
               m_dirty[idx] = 1'b1;
            end
            OP_PF_MOD, OP_WH: m_dirty[idx] = 1'b1;
            default: ;
         endcase
      end
      r0 = rd_cnt; w0 = wr_cnt;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd; req_be = be;
      @(negedge clk);
      req_valid = 1'b0;
      while (!req_ready) @(negedge clk);
      chk(rd_cnt - r0 == er, rq, "memory reads", rd_cnt - r0, er);
      chk(wr_cnt - w0 == ew, rq, "memory writes", wr_cnt - w0, ew);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total + mon_total + 1, bad + mon_bad + 1);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) exp_mem[i] = init_line(i);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(req_ready == 1'b1, "R11", "req_ready", req_ready, 1);
      chk(rsp_valid == 1'b0, "R11", "rsp_valid", rsp_valid, 0);
      chk(mem_rd_req == 1'b0 && mem_wr_req == 1'b0, "R11", "mem requests", {mem_rd_req, mem_wr_req}, 0);

      // R3 load miss into empty line, R1 hit in another word
      do_op(OP_LOAD,  16'h0040, '0, '0, "R3");
      do_op(OP_LOAD,  16'h0078, '0, '0, "R1");
      // R2 partial store hit then reload
      do_op(OP_STORE, 16'h0048, 64'hFFFF_FFFF_AAAA_BBBB, 8'h0F, "R2");
      do_op(OP_LOAD,  16'h0048, '0, '0, "R2");
      do_op(OP_STORE, 16'h0050, 64'h1122_3344_5566_7788, 8'hA5, "R2");
      do_op(OP_LOAD,  16'h0050, '0, '0, "R2");
      // R3 miss with dirty victim
      do_op(OP_LOAD,  16'h0240, '0, '0, "R3");
      do_op(OP_STORE, 16'h0440, 64'hDEAD_BEEF_0000_0001, 8'hFF, "R3");
      do_op(OP_LOAD,  16'h0440, '0, '0, "R3");
      // R4 plain prefetch
      do_op(OP_PF,    16'h0080, '0, '0, "R4");
      do_op(OP_PF,    16'h0080, '0, '0, "R4");
      do_op(OP_LOAD,  16'h0088, '0, '0, "R4");
      do_op(OP_LOAD,  16'h0280, '0, '0, "R4");
      // R5 prefetch for modify, then displacement writes back
      do_op(OP_PF_MOD, 16'h00C0, '0, '0, "R5");
      do_op(OP_STORE,  16'h00C0, 64'h0BAD_F00D_0BAD_F00D, 8'hFF, "R5");
      do_op(OP_LOAD,   16'h02C0, '0, '0, "R5");
      // R5 modify intent on a clean hit
      do_op(OP_LOAD,   16'h0100, '0, '0, "R5");
      do_op(OP_PF_MOD, 16'h0100, '0, '0, "R5");
      do_op(OP_LOAD,   16'h0300, '0, '0, "R5");
      // R7 evict-next prefetch displaced without writeback
      do_op(OP_PF_EVN, 16'h0140, '0, '0, "R7");
      do_op(OP_LOAD,   16'h0150, '0, '0, "R7");
      do_op(OP_LOAD,   16'h0340, '0, '0, "R7");
      // R7 marked line that turns dirty is written back
      do_op(OP_PF_EVN, 16'h0540, '0, '0, "R7");
      do_op(OP_STORE,  16'h0540, 64'h7777_6666_5555_4444, 8'hF0, "R7");
      do_op(OP_LOAD,   16'h0140, '0, '0, "R7");
      // R6 write hint, zero contents, dirty
      do_op(OP_WH,    16'h0180, '0, '0, "R6");
      do_op(OP_LOAD,  16'h01B8, '0, '0, "R6");
      do_op(OP_STORE, 16'h0188, 64'h0123_4567_89AB_CDEF, 8'hFF, "R6");
      do_op(OP_LOAD,  16'h0380, '0, '0, "R6");
      // R6 write hint over a dirty line of another tag
      do_op(OP_STORE, 16'h01C0, 64'hCAFE_CAFE_CAFE_CAFE, 8'hFF, "R6");
      do_op(OP_WH,    16'h03C0, '0, '0, "R6");
      do_op(OP_LOAD,  16'h03C0, '0, '0, "R6");
      // R8 evict dirty, clean, miss
      do_op(OP_STORE, 16'h0440, 64'h5A5A_5A5A_5A5A_5A5A, 8'h3C, "R8");
      do_op(OP_EVICT, 16'h0440, '0, '0, "R8");
      do_op(OP_LOAD,  16'h0440, '0, '0, "R8");
      do_op(OP_EVICT, 16'h0280, '0, '0, "R8");
      do_op(OP_LOAD,  16'h0280, '0, '0, "R8");
      do_op(OP_EVICT, 16'h0E00, '0, '0, "R8");
      // R10 reserved op
      do_op(OP_NOP,   16'h0300, '0, '0, "R10");
      do_op(OP_NOP,   16'h0A00, '0, '0, "R10");
      do_op(OP_LOAD,  16'h0300, '0, '0, "R10");
      // R4 prefetch hit is silent, no response
      do_op(OP_PF,    16'h0300, '0, '0, "R4");

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R1", "responses outstanding", exp_q.size(), 0);
      begin
         int mism;
         mism = 0;
         for (int i = 0; i < 64; i++)
            if (mem_arr[i] !== exp_mem[i]) begin
               mism++;
               $display("FAIL R3 memory line %0d act=%h exp=%h", i, mem_arr[i][63:0], exp_mem[i][63:0]);
            end
         chk(mism == 0, "R3", "memory lines differing", mism, 0);
      end
      $display("  test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
      $finish;
   end

endmodule